// File: doc/BRIEF.md
# Low-Frequency Timekeeping Counter Chain

This block keeps wall-clock time from a 32.768 kHz clock that stays alive when the processor clock is stopped. A divide-by-256 prescaler turns that clock into 128 ticks per second. The ticks feed four cascaded counters: fractions of a second (1/128 s units), seconds, minutes and hours. Each counter produces a one-cycle wrap strobe that advances the next stage. The same strobes are available at the ports so that an interval timer can choose any of them as its timebase.

Software sets the time with a small write port while the run enable is low. Each stage keeps a shadow copy of the value written last. Whenever the run enable is low, the live count is forced back to that shadow copy, so stopping the clock always restores the programmed time. A mode input selects whether the hour counter wraps after 23 or runs freely up to 255. The write port expects its strobe to be synchronous to the 32.768 kHz clock already.

Top module: `rtc_chain`

## Requirements
- R1: A low `rst_n` at a clock edge clears all four counts and all four shadow copies to 0. The tick and wrap strobes are low after that edge.
- R2: While `run_en` is high, `tick_o` pulses for one cycle in every 256 clock cycles, and the fraction count advances once per pulse. The first pulse comes 256 cycles after `run_en` rises.
- R3: The fraction count runs 0 to 127. On the advance from 127 it returns to 0 and `frac_wrap_o` pulses for one cycle, which advances the seconds count.
- R4: The seconds count runs 0 to 59. On the advance from 59 it returns to 0 and `sec_wrap_o` pulses, which advances the minutes count.
- R5: The minutes count runs 0 to 59. On the advance from 59 it returns to 0 and `min_wrap_o` pulses, which advances the hours count.
- R6: With `hour24_en` high, the hours count runs 0 to 23. On the advance from 23 it returns to 0 and `hour_wrap_o` pulses.
- R7: With `hour24_en` low, the hours count runs 0 to 255. It steps from 23 to 24 without a strobe, and on the advance from 255 it returns to 0 with `hour_wrap_o`.
- R8: While `run_en` is low, no strobe fires and no count advances. The prescaler phase is reset, so the next run starts a full 256-cycle tick period.
- R9: A write with `run_en` low loads `wr_data` into the addressed stage, and the port shows it after that edge. The field codes on `wr_sel` are 0 for fraction, 1 for seconds, 2 for minutes and 3 for hours.
- R10: A write with `run_en` high changes neither the live count nor the stored value that a later stop reloads.
- R11: At every edge with `run_en` low and no write, each count is reloaded with the value written to it last. Dropping `run_en` therefore restores the programmed time one cycle later.
- R12: A count preloaded at or above its stage limit returns to 0 on its next advance and emits its wrap strobe, like a normal wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | 32.768 kHz timekeeping clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Counting enable; low stops counting and restores the written time |
| hour24_en | input | 1 | 1: hours wrap after 23; 0: hours wrap after 255 |
| wr_stb | input | 1 | Write strobe, already synchronous to clk_lf |
| wr_sel | input | 2 | Field select: 0 fraction, 1 seconds, 2 minutes, 3 hours |
| wr_data | input | 8 | Value to load |
| tick_o | output | 1 | One-cycle pulse at 128 Hz |
| frac_wrap_o | output | 1 | One-cycle pulse when the fraction count wraps |
| sec_wrap_o | output | 1 | One-cycle pulse when the seconds count wraps |
| min_wrap_o | output | 1 | One-cycle pulse when the minutes count wraps |
| hour_wrap_o | output | 1 | One-cycle pulse when the hours count wraps |
| frac_o | output | 8 | Fraction count, 1/128 s units |
| sec_o | output | 8 | Seconds count |
| min_o | output | 8 | Minutes count |
| hour_o | output | 8 | Hours count |

## Verification
A wrong prescaler phase shows first as a fraction count that is one tick early or late in the cycle after the 256th edge of a run. An error in a stage limit shows only when that stage wraps. The preloads therefore put every stage at or above its limit, so the fault appears at the ports within one tick instead of hours later. A corrupted shadow copy stays hidden while the chain runs. It appears in the single cycle after `run_en` falls, so every test ends by stopping the chain and comparing the reloaded time with the values that were written.

// File: rtl/rtc_pkg.sv
// Shared definitions for the timekeeping counter chain.
// Assumes: every stage value fits in VAL_W bits.
package rtc_pkg;

    localparam int VAL_W = 8;

    // Field codes on the write select input; the order is part of the port contract.
    typedef enum logic [1:0] {
        FLD_FRAC = 2'd0,
        FLD_SEC  = 2'd1,
        FLD_MIN  = 2'd2,
        FLD_HOUR = 2'd3
    } field_e;

    localparam int NUM_FIELDS = 4;

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the low-frequency clock by DIV and emits a one-cycle tick.
// Assumes: DIV is at least 2. The phase is held at zero while run_en is low,
// so every run starts with a full tick period.
module rtc_prescaler #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // Tick on the final phase of a running period.
    always_comb tick_o = run_en && (phase_q == LAST);

    // Phase counter: cleared by reset or stop, restarted after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run_en || tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R8: a stopped prescaler restarts from phase zero
    p_idle_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (phase_q == '0));

    // R2: the tick never lasts longer than one cycle
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R1: reset leaves the phase at zero
    p_reset_phase_r1: assert property (@(posedge clk)
        !rst_n |=> (phase_q == '0));

endmodule

// File: rtl/rtc_wr_decode.sv
// Turns the write strobe and field code into per-stage write enables.
// Assumes: wr_stb is already synchronous to clk. Writes are blocked while run_en is high.
module rtc_wr_decode
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_en,
    input  logic                  wr_stb,
    input  logic [1:0]            wr_sel,
    output logic [NUM_FIELDS-1:0] wr_en_o
);
    field_e fld;

    always_comb fld = field_e'(wr_sel);

    // One enable per field, active only for a write while stopped.
    always_comb begin
        wr_en_o = '0;
        if (wr_stb && !run_en) begin
            unique case (fld)
                FLD_FRAC: wr_en_o[0] = 1'b1;
                FLD_SEC:  wr_en_o[1] = 1'b1;
                FLD_MIN:  wr_en_o[2] = 1'b1;
                FLD_HOUR: wr_en_o[3] = 1'b1;
            endcase
        end
    end

    // R9: a write never addresses two stages at once
    p_one_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_o));

    // R10: no stage sees a write enable while the chain runs
    p_no_write_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en || !wr_stb) |-> ($countones(wr_en_o) == 0));

endmodule

// File: rtl/rtc_stage.sv
// One counter stage. It counts 0..limit on each advance and emits a wrap strobe.
// It keeps a shadow of the last value written to it.
// Assumes: writes arrive only while run_en is low. A value at or above the limit
// wraps on the next advance. lim_sel picks LIM_A (1) or LIM_B (0); give both the
// same value for a stage with a fixed limit.
module rtc_stage #(
    parameter int VAL_W = 8,
    parameter int LIM_A = 59,
    parameter int LIM_B = 59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             adv_i,
    input  logic             lim_sel_i,
    input  logic             wr_en_i,
    input  logic [VAL_W-1:0] wr_data_i,
    output logic [VAL_W-1:0] q_o,
    output logic             wrap_o
);
    localparam logic [VAL_W-1:0] TOP_A = VAL_W'(LIM_A);
    localparam logic [VAL_W-1:0] TOP_B = VAL_W'(LIM_B);

    logic [VAL_W-1:0] cnt_q;
    logic [VAL_W-1:0] shadow_q;
    logic [VAL_W-1:0] top;
    logic             at_top;

    // Select the active wrap limit.
    always_comb top = lim_sel_i ? TOP_A : TOP_B;

    // At or beyond the limit, the next advance wraps.
    always_comb at_top = (cnt_q >= top);

    // Carry to the next stage on a wrapping advance.
    always_comb wrap_o = run_en && adv_i && at_top;

    always_comb q_o = cnt_q;

    // Count, preload and reload from the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shadow_q <= '0;
        end else if (!run_en) begin
            if (wr_en_i) begin
                shadow_q <= wr_data_i;
                cnt_q    <= wr_data_i;
            end else begin
                cnt_q    <= shadow_q;
            end
        end else if (adv_i) begin
            cnt_q <= at_top ? '0 : cnt_q + 1'b1;
        end
    end

    // R3 R4 R5 R6 R7 R12: a wrap strobe is followed by a zero count
    p_wrap_to_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));

    // R3 R4 R5 R6 R7: a non-wrapping advance steps by exactly one
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && adv_i && !wrap_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R8: without an advance a running count holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !adv_i) |=> $stable(cnt_q));

    // R10: the shadow cannot change while running
    p_shadow_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> $stable(shadow_q));

    // R11: a stopped stage without a write shows its shadow
    p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_en_i) |=> (cnt_q == $past(shadow_q)));

    // R9: a stopped write lands in the live count
    p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && wr_en_i) |=> (cnt_q == $past(wr_data_i)));

    // R1: reset clears the count
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && shadow_q == '0));

endmodule

// File: rtl/rtc_chain.sv
// Timekeeping chain: a 128 Hz prescaler followed by fraction, second, minute
// and hour stages. Each stage's wrap strobe advances the next stage.
// Assumes: clk_lf is the 32.768 kHz clock and the write strobe is synchronous to it.
module rtc_chain
    import rtc_pkg::*;
#(
    parameter int PRESC_DIV   = 256,
    parameter int FRAC_STEPS  = 128,
    parameter int SEC_STEPS   = 60,
    parameter int MIN_STEPS   = 60,
    parameter int HOUR_DAY    = 24,
    parameter int HOUR_FREE   = 256
) (
    input  logic             clk_lf,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             hour24_en,
    input  logic             wr_stb,
    input  logic [1:0]       wr_sel,
    input  logic [VAL_W-1:0] wr_data,
    output logic             tick_o,
    output logic             frac_wrap_o,
    output logic             sec_wrap_o,
    output logic             min_wrap_o,
    output logic             hour_wrap_o,
    output logic [VAL_W-1:0] frac_o,
    output logic [VAL_W-1:0] sec_o,
    output logic [VAL_W-1:0] min_o,
    output logic [VAL_W-1:0] hour_o
);
    localparam int FRAC_TOP = FRAC_STEPS - 1;
    localparam int SEC_TOP  = SEC_STEPS - 1;
    localparam int MIN_TOP  = MIN_STEPS - 1;
    localparam int HDAY_TOP = HOUR_DAY - 1;
    localparam int HFRE_TOP = HOUR_FREE - 1;

    logic [NUM_FIELDS-1:0] wr_en;
    logic [NUM_FIELDS:0]   carry;
    logic [VAL_W-1:0]      val [NUM_FIELDS];

    rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk    (clk_lf),
        .rst_n  (rst_n),
        .run_en (run_en),
        .tick_o (carry[0])
    );

    rtc_wr_decode u_dec (
        .clk     (clk_lf),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .wr_stb  (wr_stb),
        .wr_sel  (wr_sel),
        .wr_en_o (wr_en)
    );

    // Stage limits differ; the hour stage alone uses a selectable pair.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_stage
        localparam int LA = (g == 0) ? FRAC_TOP : (g == 1) ? SEC_TOP :
                            (g == 2) ? MIN_TOP  : HDAY_TOP;
        localparam int LB = (g == 3) ? HFRE_TOP : LA;
        rtc_stage #(.VAL_W(VAL_W), .LIM_A(LA), .LIM_B(LB)) u_stage (
            .clk       (clk_lf),
            .rst_n     (rst_n),
            .run_en    (run_en),
            .adv_i     (carry[g]),
            .lim_sel_i (hour24_en),
            .wr_en_i   (wr_en[g]),
            .wr_data_i (wr_data),
            .q_o       (val[g]),
            .wrap_o    (carry[g+1])
        );
    end

    // Bring strobes and counts out to the ports.
    always_comb begin
        tick_o      = carry[0];
        frac_wrap_o = carry[1];
        sec_wrap_o  = carry[2];
        min_wrap_o  = carry[3];
        hour_wrap_o = carry[4];
        frac_o      = val[0];
        sec_o       = val[1];
        min_o       = val[2];
        hour_o      = val[3];
    end

    // R6: in day mode the hours never exceed the day limit once they have wrapped
    p_day_wrap_r6: assert property (@(posedge clk_lf) disable iff (!rst_n)
        (hour24_en && hour_wrap_o) |=> (hour_o == '0));

    // R8: no strobe of any kind while stopped
    p_quiet_stopped_r8: assert property (@(posedge clk_lf) disable iff (!rst_n)
        !run_en |-> (carry == '0));

    // R1: strobes are low right after reset
    p_reset_strobes_r1: assert property (@(posedge clk_lf)
        !rst_n |=> (carry == '0));

endmodule

// File: tb/rtc_chain_test.sv
module rtc_chain_test;

    localparam int TICK = 256;   // R2: clock cycles per tick

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       hour24_en = 1'b1;
    logic       wr_stb = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       tick_o, frac_wrap_o, sec_wrap_o, min_wrap_o, hour_wrap_o;
    logic [7:0] frac_o, sec_o, min_o, hour_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int n_tick = 0, n_fw = 0, n_sw = 0, n_mw = 0, n_hw = 0;

    always #4 clk = ~clk;

    rtc_chain uut (
        .clk_lf(clk), .rst_n(rst_n), .run_en(run_en), .hour24_en(hour24_en),
        .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick_o(tick_o), .frac_wrap_o(frac_wrap_o), .sec_wrap_o(sec_wrap_o),
        .min_wrap_o(min_wrap_o), .hour_wrap_o(hour_wrap_o),
        .frac_o(frac_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o)
    );

    // Count strobe cycles, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            n_tick += int'(tick_o);
            n_fw   += int'(frac_wrap_o);
            n_sw   += int'(sec_wrap_o);
            n_mw   += int'(min_wrap_o);
            n_hw   += int'(hour_wrap_o);
        end
    end

    typedef struct packed {
        logic       h24;
        logic [7:0] ph, pm, ps, pf;
        logic [7:0] eh, em, es, ef;
        logic [3:0] mask;   // {hour, min, sec, frac} wrap strobes expected
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'd0,   8'd0,  8'd0,  8'd0,   8'd0,   8'd0,  8'd0, 8'd1,  4'b0000}, // R2
        '{1'b1, 8'd0,   8'd0,  8'd0,  8'd127, 8'd0,   8'd0,  8'd1, 8'd0,  4'b0001}, // R3
        '{1'b1, 8'd0,   8'd0,  8'd59, 8'd127, 8'd0,   8'd1,  8'd0, 8'd0,  4'b0011}, // R4
        '{1'b1, 8'd0,   8'd59, 8'd59, 8'd127, 8'd1,   8'd0,  8'd0, 8'd0,  4'b0111}, // R5
        '{1'b1, 8'd23,  8'd59, 8'd59, 8'd127, 8'd0,   8'd0,  8'd0, 8'd0,  4'b1111}, // R6
        '{1'b0, 8'd23,  8'd59, 8'd59, 8'd127, 8'd24,  8'd0,  8'd0, 8'd0,  4'b0111}, // R7
        '{1'b0, 8'd255, 8'd59, 8'd59, 8'd127, 8'd0,   8'd0,  8'd0, 8'd0,  4'b1111}, // R7
        '{1'b1, 8'd5,   8'd12, 8'd30, 8'd64,  8'd5,   8'd12, 8'd30, 8'd65, 4'b0000},
        '{1'b1, 8'd0,   8'd0,  8'd75, 8'd127, 8'd0,   8'd1,  8'd0, 8'd0,  4'b0011}, // R12
        '{1'b1, 8'd40,  8'd59, 8'd59, 8'd127, 8'd0,   8'd0,  8'd0, 8'd0,  4'b1111}, // R12
        '{1'b0, 8'd200, 8'd59, 8'd59, 8'd127, 8'd201, 8'd0,  8'd0, 8'd0,  4'b0111}, // R7
        '{1'b1, 8'd22,  8'd59, 8'd59, 8'd127, 8'd23,  8'd0,  8'd0, 8'd0,  4'b0111}, // R6
        '{1'b1, 8'd0,   8'd0,  8'd0,  8'd200, 8'd0,   8'd0,  8'd1, 8'd0,  4'b0001}  // R12
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_time(input string req, input int h, input int m, input int s, input int f);
        chk(req, "hour", int'(hour_o), h);
        chk(req, "min",  int'(min_o),  m);
        chk(req, "sec",  int'(sec_o),  s);
        chk(req, "frac", int'(frac_o), f);
    endtask

    task automatic write_fld(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic preload(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s, input logic [7:0] f);
        write_fld(2'd3, h);
        write_fld(2'd2, m);
        write_fld(2'd1, s);
        write_fld(2'd0, f);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t0, f0, s0, m0, h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk_time("R1", 0, 0, 0, 0);
        chk("R1", "strobes", int'({tick_o, frac_wrap_o, sec_wrap_o, min_wrap_o, hour_wrap_o}), 0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            hour24_en = VEC[i].h24;
            preload(VEC[i].ph, VEC[i].pm, VEC[i].ps, VEC[i].pf);
            @(negedge clk);
            chk_time("R9", int'(VEC[i].ph), int'(VEC[i].pm), int'(VEC[i].ps), int'(VEC[i].pf));
            t0 = n_tick; f0 = n_fw; s0 = n_sw; m0 = n_mw; h0 = n_hw;
            run_en = 1'b1;
            repeat (TICK) @(posedge clk);
            @(negedge clk);
            chk_time("R2-vec", int'(VEC[i].eh), int'(VEC[i].em), int'(VEC[i].es), int'(VEC[i].ef));
            chk("R2", "ticks", n_tick - t0, 1);
            chk("R3", "frac wraps", n_fw - f0, int'(VEC[i].mask[0]));
            chk("R4", "sec wraps",  n_sw - s0, int'(VEC[i].mask[1]));
            chk("R5", "min wraps",  n_mw - m0, int'(VEC[i].mask[2]));
            chk("R6", "hour wraps", n_hw - h0, int'(VEC[i].mask[3]));
            run_en = 1'b0;
            @(negedge clk);
            // R11: stopping restores the written time
            chk_time("R11", int'(VEC[i].ph), int'(VEC[i].pm), int'(VEC[i].ps), int'(VEC[i].pf));
        end

        // R8: stopped chain holds and stays quiet
        hour24_en = 1'b1;
        preload(8'd7, 8'd8, 8'd9, 8'd10);
        t0 = n_tick; f0 = n_fw;
        repeat (300) @(negedge clk);
        chk_time("R8", 7, 8, 9, 10);
        chk("R8", "ticks stopped", n_tick - t0, 0);
        chk("R8", "wraps stopped", n_fw - f0, 0);

        // R2: two full periods give two ticks, first at 256 cycles
        t0 = n_tick;
        run_en = 1'b1;
        repeat (TICK - 1) @(posedge clk);
        @(negedge clk);
        chk("R2", "frac before first tick", int'(frac_o), 10);
        @(posedge clk);
        repeat (TICK) @(posedge clk);
        @(negedge clk);
        chk("R2", "frac after two ticks", int'(frac_o), 12);
        chk("R2", "tick count", n_tick - t0, 2);
        run_en = 1'b0;
        @(negedge clk);

        // R10: writes while running are ignored
        preload(8'd1, 8'd2, 8'd10, 8'd3);
        run_en = 1'b1;
        repeat (5) @(negedge clk);
        write_fld(2'd1, 8'd33);
        write_fld(2'd3, 8'd17);
        @(negedge clk);
        chk("R10", "sec live", int'(sec_o), 10);
        chk("R10", "hour live", int'(hour_o), 1);
        run_en = 1'b0;
        @(negedge clk);
        chk("R10", "sec reload", int'(sec_o), 10);
        chk("R10", "hour reload", int'(hour_o), 1);

        // R1: reset while running clears counts and stored values
        run_en = 1'b1;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_time("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        run_en = 1'b0;
        repeat (2) @(negedge clk);
        chk_time("R1", 0, 0, 0, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule